// File: doc/BRIEF.md
# Slot-Mapped Audio Transmit Channel

This block is one outbound audio channel of a serial codec link. A processor writes 16-bit sample words into an eight-entry queue. The frame engine of the link raises a request strobe for each slot of the frame and gives the slot index with it. When the index belongs to this channel, the block takes the oldest word off the queue. One clock later it returns the word as a 20-bit slot value, with the word in the upper 16 bits.

A single 16-bit control/status register sets up the channel. Its fields are a link-enable code, a mono/stereo choice, the first slot served, a free-space threshold and a request-enable bit. It also reads back queue full, queue empty and a sticky underflow flag. In stereo mode the channel serves the chosen slot and the slot after it. The queue therefore holds samples in left/right order. A level interrupt tells software when enough space is free, and a matching request line can drive a transfer engine.

Top module: `slot_tx_channel`

## Requirements
- R1: The queue holds 8 words in first-in first-out order. A data write while the queue is full is dropped, and the queue contents stay unchanged. Register bit 13 reads 1 when the queue is full. Bit 14 reads 1 when it is empty.
- R2: The channel is enabled only when register bits [1:0] equal 2'b10. With 00, 01 or 11 it serves no slot request.
- R3: Bits [7:4] hold the slot code, and only codes 3 to 12 are legal. Codes 0-2 and 13-15 never cause a pop. Code 12 with stereo set never causes a pop either.
- R4: With bit 3 clear (mono), only a request whose slot index equals the code is served.
- R5: With bit 3 set (stereo), requests for slot code and for slot code+1 are both served in arrival order, so the first queued word goes to the first slot.
- R6: A served request sets slot_valid in the next cycle, with slot_data = {word, 4'b0000}. Requests that are not served leave slot_valid low.
- R7: A served request that finds the queue empty sets sticky bit 15 and returns slot_data = 0 with slot_valid high. The queue pointers do not move. A register write with bit 15 = 1 clears the flag, and a write with bit 15 = 0 leaves it as it was.
- R8: irq is high while the channel is enabled and the free entries number at least bits[10:8]+1. dma_req equals irq gated by bit 11.
- R9: After reset every stored bit is zero. The register reads 16'h4000, and irq, dma_req and slot_valid are low.
- R10: Bits [11:0] read back as written, except reserved bits 2 and 12, which read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 16 | Register write value |
| csr_rdata | output | 16 | Register read value (control plus status) |
| data_wr | input | 1 | Queue write strobe |
| data_wdata | input | 16 | Sample word to queue |
| slot_req | input | 1 | Frame engine asks for one slot value |
| slot_num | input | 4 | Index of the requested slot |
| slot_valid | output | 1 | slot_data answers last cycle's served request |
| slot_data | output | 20 | Slot value returned |
| irq | output | 1 | Level interrupt on free space |
| dma_req | output | 1 | Transfer request (interrupt condition and enable) |

## Verification
The assertions check several properties on every cycle. The queue occupancy never exceeds its depth. A write into a full queue leaves the occupancy unchanged. Every slot value has a zero pad nibble, and an answer to an empty queue is all zero. The underflow flag rises only after a slot request. An illegal configuration never yields a served slot, and the interrupt never fires while the channel is disabled. The bench scenarios show the rest: the word order through the queue, the stereo pairing of slots, the threshold arithmetic, the write-one-to-clear behaviour and the register readback, all against values the bench predicts.

// File: rtl/slot_tx_pkg.sv
package slot_tx_pkg;
    localparam int SLOTNUM_W  = 4;
    localparam int THR_W      = 3;
    localparam int FIRST_SLOT = 3;
    localparam int LAST_SLOT  = 12;
    localparam logic [1:0] LINK_ON = 2'b10;

    typedef struct packed {
        logic                 uf;
        logic                 req_en;
        logic [THR_W-1:0]     thr;
        logic [SLOTNUM_W-1:0] code;
        logic                 stereo;
        logic [1:0]           link;
    } ctrl_t;
endpackage

// File: rtl/slot_tx_store.sv
module slot_tx_store #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic                          pop,
    input  logic [WORD_W-1:0]             wdata,
    output logic [WORD_W-1:0]             rdata,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          full,
    output logic                          empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH-1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign full    = (st_q.cnt == CNT_W'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem_q[st_q.rp];
    assign count   = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (push_ok) st_d.wp = (st_q.wp == PTR_LAST) ? '0 : st_q.wp + 1'b1;
        if (pop_ok)  st_d.rp = (st_q.rp == PTR_LAST) ? '0 : st_q.rp + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= wdata;
    end

    // R1: occupancy bounded by depth
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    // R1: write into a full queue without a pop leaves occupancy unchanged
    a_r1_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(st_q.cnt));
endmodule

// File: rtl/slot_tx_match.sv
module slot_tx_match
    import slot_tx_pkg::*;
(
    input  logic [1:0]           link,
    input  logic                 stereo,
    input  logic [SLOTNUM_W-1:0] code,
    input  logic                 req,
    input  logic [SLOTNUM_W-1:0] slot_num,
    output logic                 cfg_ok,
    output logic                 hit
);
    logic code_legal, index_match;

    always_comb begin
        code_legal  = (code >= SLOTNUM_W'(FIRST_SLOT)) && (code <= SLOTNUM_W'(LAST_SLOT))
                      && !(stereo && code == SLOTNUM_W'(LAST_SLOT));
        cfg_ok      = (link == LINK_ON) && code_legal;
        index_match = (slot_num == code) || (stereo && slot_num == code + 1'b1);
        hit         = req && cfg_ok && index_match;
    end
endmodule

// File: rtl/slot_tx_channel.sv
module slot_tx_channel
    import slot_tx_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 16,
    parameter int PAD_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      csr_wr,
    input  logic [15:0]               csr_wdata,
    output logic [15:0]               csr_rdata,
    input  logic                      data_wr,
    input  logic [WORD_W-1:0]         data_wdata,
    input  logic                      slot_req,
    input  logic [SLOTNUM_W-1:0]      slot_num,
    output logic                      slot_valid,
    output logic [WORD_W+PAD_W-1:0]   slot_data,
    output logic                      irq,
    output logic                      dma_req
);
    localparam int CNT_W  = $clog2(DEPTH+1);
    localparam int SLOT_W = WORD_W + PAD_W;

    typedef struct packed {
        ctrl_t             ctrl;
        logic              sv;
        logic [SLOT_W-1:0] sd;
    } top_t;

    top_t t_d, t_q;
    logic [WORD_W-1:0] head_word;
    logic [CNT_W-1:0]  fill;
    logic              q_full, q_empty, cfg_ok, hit;
    logic [CNT_W-1:0]  free_cnt;

    slot_tx_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (data_wr),
        .pop   (hit),
        .wdata (data_wdata),
        .rdata (head_word),
        .count (fill),
        .full  (q_full),
        .empty (q_empty)
    );

    slot_tx_match u_match (
        .link     (t_q.ctrl.link),
        .stereo   (t_q.ctrl.stereo),
        .code     (t_q.ctrl.code),
        .req      (slot_req),
        .slot_num (slot_num),
        .cfg_ok   (cfg_ok),
        .hit      (hit)
    );

    always_comb begin
        t_d    = t_q;
        t_d.sv = 1'b0;
        if (csr_wr) begin
            t_d.ctrl.link   = csr_wdata[1:0];
            t_d.ctrl.stereo = csr_wdata[3];
            t_d.ctrl.code   = csr_wdata[7:4];
            t_d.ctrl.thr    = csr_wdata[10:8];
            t_d.ctrl.req_en = csr_wdata[11];
            if (csr_wdata[15]) t_d.ctrl.uf = 1'b0;
        end
        if (hit) begin
            t_d.sv = 1'b1;
            if (q_empty) begin
                t_d.ctrl.uf = 1'b1;
                t_d.sd      = '0;
            end else begin
                t_d.sd = {head_word, {PAD_W{1'b0}}};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    always_comb begin
        free_cnt   = CNT_W'(DEPTH) - fill;
        irq        = (t_q.ctrl.link == LINK_ON) && (32'(free_cnt) > 32'(t_q.ctrl.thr));
        dma_req    = irq && t_q.ctrl.req_en;
        slot_valid = t_q.sv;
        slot_data  = t_q.sd;
        csr_rdata  = {t_q.ctrl.uf, q_empty, q_full, 1'b0, t_q.ctrl.req_en, t_q.ctrl.thr,
                      t_q.ctrl.code, t_q.ctrl.stereo, 1'b0, t_q.ctrl.link};
    end

    // R6: pad nibble of every returned slot value is zero
    a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |-> (slot_data[PAD_W-1:0] == '0));
    // R7: a slot answered from an empty queue carries zero
    a_r7_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && $past(q_empty)) |-> (slot_data == '0));
    // R7: underflow flag only rises after a slot request
    a_r7_uf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_q.ctrl.uf) |-> $past(slot_req));
    // R3: an illegal or disabled configuration never serves a slot
    a_r3_no_serve: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |=> !slot_valid);
    // R8: interrupt only while the link is enabled
    a_r8_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (csr_rdata[1:0] == LINK_ON));
endmodule

// File: tb/slot_tx_channel_test.sv
module slot_tx_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [15:0] csr_wdata = '0;
    logic [15:0] csr_rdata;
    logic        data_wr = 1'b0;
    logic [15:0] data_wdata = '0;
    logic        slot_req = 1'b0;
    logic [3:0]  slot_num = '0;
    logic        slot_valid;
    logic [19:0] slot_data;
    logic        irq, dma_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    slot_tx_channel uut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .data_wr(data_wr), .data_wdata(data_wdata),
        .slot_req(slot_req), .slot_num(slot_num), .slot_valid(slot_valid),
        .slot_data(slot_data), .irq(irq), .dma_req(dma_req)
    );

    // op: 0 register write, 1 data write, 2 slot request (arg[3:0] = index)
    localparam int NV = 28;
    localparam logic [38:0] VEC [NV] = '{
        {2'd0, 16'h0352, 1'b0, 20'h0},      // mono slot 5, thr 3
        {2'd1, 16'h1234, 1'b0, 20'h0},
        {2'd1, 16'hABCD, 1'b0, 20'h0},
        {2'd2, 16'h0004, 1'b0, 20'h0},      // R4 other slot
        {2'd2, 16'h0005, 1'b1, 20'h12340},  // R6
        {2'd2, 16'h0006, 1'b0, 20'h0},      // R4 next slot not served in mono
        {2'd2, 16'h0005, 1'b1, 20'hABCD0},  // R1 order
        {2'd2, 16'h0005, 1'b1, 20'h00000},  // R7 underflow
        {2'd0, 16'h007A, 1'b0, 20'h0},      // stereo slots 7/8
        {2'd1, 16'h1111, 1'b0, 20'h0},
        {2'd1, 16'h2222, 1'b0, 20'h0},
        {2'd2, 16'h0007, 1'b1, 20'h11110},  // R5 left
        {2'd2, 16'h0008, 1'b1, 20'h22220},  // R5 right
        {2'd2, 16'h0009, 1'b0, 20'h0},
        {2'd0, 16'h00CA, 1'b0, 20'h0},      // stereo code 12: illegal
        {2'd1, 16'h5555, 1'b0, 20'h0},
        {2'd2, 16'h000C, 1'b0, 20'h0},      // R3
        {2'd2, 16'h000D, 1'b0, 20'h0},      // R3
        {2'd0, 16'h00C2, 1'b0, 20'h0},      // mono code 12: legal
        {2'd2, 16'h000C, 1'b1, 20'h55550},  // R3
        {2'd0, 16'h0031, 1'b0, 20'h0},      // link code 01
        {2'd1, 16'h7777, 1'b0, 20'h0},
        {2'd2, 16'h0003, 1'b0, 20'h0},      // R2
        {2'd0, 16'h0022, 1'b0, 20'h0},      // code 2 reserved
        {2'd2, 16'h0002, 1'b0, 20'h0},      // R3
        {2'd0, 16'h0032, 1'b0, 20'h0},
        {2'd2, 16'h0004, 1'b0, 20'h0},      // R4
        {2'd2, 16'h0003, 1'b1, 20'h77770}   // R2 enabled again
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic [15:0] arg);
        @(negedge clk);
        csr_wr     = (op == 2'd0);
        data_wr    = (op == 2'd1);
        slot_req   = (op == 2'd2);
        csr_wdata  = arg;
        data_wdata = arg;
        slot_num   = arg[3:0];
        @(negedge clk);
        csr_wr = 1'b0; data_wr = 1'b0; slot_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 rdata", 32'(csr_rdata), 32'h4000);
        check("R9 irq", 32'(irq), 0);
        check("R9 dma_req", 32'(dma_req), 0);
        check("R9 slot_valid", 32'(slot_valid), 0);

        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][38:37], VEC[i][36:21]);
            check($sformatf("R6 vec%0d valid", i), 32'(slot_valid), 32'(VEC[i][20]));
            if (VEC[i][20]) check($sformatf("R6 vec%0d data", i), 32'(slot_data), 32'(VEC[i][19:0]));
        end

        // R7 sticky, write-one-to-clear
        check("R7 sticky", 32'(csr_rdata[15]), 1);
        do_op(0, 16'h0032);
        check("R7 write0 keeps", 32'(csr_rdata[15]), 1);
        do_op(0, 16'h8032);
        check("R7 write1 clears", 32'(csr_rdata[15]), 0);

        // R1 full and dropped write
        for (int i = 0; i < 9; i++) do_op(1, 16'h0100 + 16'(i));
        check("R1 full flag", 32'(csr_rdata[14:13]), 32'b01);
        for (int i = 0; i < 8; i++) begin
            do_op(2, 16'h0003);
            check("R1 order", 32'(slot_data), 32'({16'h0100 + 16'(i), 4'h0}));
        end
        check("R1 empty flag", 32'(csr_rdata[14:13]), 32'b10);
        do_op(2, 16'h0003);
        check("R7 dropped write left nothing", 32'(slot_data), 0);
        check("R7 flag set", 32'(csr_rdata[15]), 1);

        // R8 threshold 3: irq while free >= 4
        do_op(0, 16'h8B32);
        for (int i = 0; i < 5; i++) do_op(1, 16'h0200 + 16'(i));
        check("R8 irq low free3", 32'(irq), 0);
        check("R8 dma low free3", 32'(dma_req), 0);
        do_op(2, 16'h0003);
        check("R8 irq high free4", 32'(irq), 1);
        check("R8 dma high", 32'(dma_req), 1);
        do_op(0, 16'h0332);
        check("R8 dma gated", 32'(dma_req), 0);
        check("R8 irq kept", 32'(irq), 1);
        do_op(0, 16'h0330);
        check("R8 irq disabled", 32'(irq), 0);

        // R10 readback, reserved bits read zero
        do_op(0, 16'h1FFF);
        check("R10 readback", 32'(csr_rdata), 32'h0FFB);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule